// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus and frees the bus after a transfer was cut short or after a reset. A target that was part-way through sending a byte may still be holding the data line low. When this happens no controller can issue a START. On a request, the sequencer pulses the clock line and checks the data line near the end of every clock-high phase. At the first pulse where the data line reads high it stops clocking. It then drives a START followed by a STOP, which leaves every target on the bus waiting for a fresh address.

Both lines are driven open-drain. Each output is an enable where 1 pulls the line low and 0 releases it. A line is never driven high. The length of each clock phase is set by a parameter counted in system clocks. The returned data line passes through a synchroniser before it is sampled. If the data line is still low after the ninth pulse, the block gives up, releases both lines and reports failure. Completion is marked by a one-cycle `done`. The `fail` flag tells success from failure and holds until the next accepted request.

Top module: `bus_recover`

## Requirements
- R1: After reset both `scl_oe` and `sda_oe` are 0 (both lines released), and `busy`, `done` and `fail` are 0.
- R2: `req` is accepted only while `busy` is 0. A `req` asserted while `busy` is 1 has no effect, so one accepted request yields exactly one `done` pulse and one sequence.
- R3: Every clock-low phase driven by the block lasts exactly `HALF_CYCLES` system clocks, and so does every phase of the START/STOP sequence.
- R4: The synchronised data line is sampled in the last cycle of each clock-high phase. Clocking stops at the first pulse whose sample is high, and at least one pulse is always issued.
- R5: No more than `MAX_PULSES` (9) clock pulses are issued per request.
- R6: On success the block pulls the data line low while the clock is released (START). It then pulls the clock low, releases the clock, and releases the data line while the clock is released (STOP), so both lines end released and `fail` is 0.
- R7: If the sample of the ninth pulse is still low, no START or STOP is produced, both lines end released, and `fail` becomes 1 together with `done`.
- R8: `done` is high for exactly one cycle at the end of a sequence. `busy` is 1 from the cycle after acceptance up to the cycle `done` rises.
- R9: `sda_oe` changes while the clock is released only at the START and STOP edges. Every other change happens while the clock is held low.
- R10: The outputs are open-drain enables: 1 pulls the line low, 0 releases it, and no output drives a line high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a recovery sequence (taken only when idle) |
| sda_i | input | 1 | Level read back from the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence strobe |
| fail | output | 1 | Data line stayed low after the last pulse |

## Verification
The decision of which sequence to finish with is made in the same cycle for two possible results. On the ninth pulse, the last clock-high sample can either release the bus or exhaust the pulse budget. A target that lets go exactly on the ninth rising edge must lead to a START/STOP and no failure, while one that lets go a pulse later must lead to failure. The bench drives a simulated target that releases the data line at a chosen rising edge, and sweeps that edge from "never held" through 9 up to "never released". For each case it derives the pulse count, the START/STOP edges, the clock-low cycle total and the final flags by arithmetic. A second request is also injected while every sequence is running, and the bench checks it changes nothing.

// File: rtl/rec_pkg.sv
package rec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_START,
    ST_SLOW,
    ST_SHIGH,
    ST_STOP
  } rec_state_t;
endpackage

// File: rtl/rec_sync.sv
module rec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= 1'b1;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rec_phase_timer.sv
module rec_phase_timer #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic last
);
  localparam int W = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [W-1:0] LAST_V = W'(HALF_CYCLES - 1);

  logic [W-1:0] cnt;

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst || clr || last) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_V);
endmodule

// File: rtl/rec_pulse_counter.sv
module rec_pulse_counter #(
  parameter int MAX_PULSES = 9,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // R5
  pulse_lim_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAX_PULSES));
endmodule

// File: rtl/bus_recover.sv
module bus_recover
  import rec_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic sda_i,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic fail
);
  localparam int CW = $clog2(MAX_PULSES + 1);

  rec_state_t st, nxt;
  logic          sda_s;
  logic          last;
  logic [CW-1:0] pulse_cnt;
  logic          accept;
  logic          finish;
  logic          give_up;
  logic          final_pulse;

  rec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sda_i),
    .q   (sda_s)
  );

  rec_phase_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (st == ST_IDLE),
    .last (last)
  );

  assign accept      = (st == ST_IDLE) && req;
  assign final_pulse = (pulse_cnt == CW'(MAX_PULSES - 1));

  rec_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .inc ((st == ST_HIGH) && last),
    .cnt (pulse_cnt)
  );

  always_comb begin
    nxt     = st;
    finish  = 1'b0;
    give_up = 1'b0;
    unique case (st)
      ST_IDLE:  if (req) nxt = ST_LOW;
      ST_LOW:   if (last) nxt = ST_HIGH;
      ST_HIGH:
        if (last) begin
          if (sda_s) begin
            nxt = ST_START;
          end else if (final_pulse) begin
            nxt     = ST_IDLE;
            finish  = 1'b1;
            give_up = 1'b1;
          end else begin
            nxt = ST_LOW;
          end
        end
      ST_START: if (last) nxt = ST_SLOW;
      ST_SLOW:  if (last) nxt = ST_SHIGH;
      ST_SHIGH: if (last) nxt = ST_STOP;
      ST_STOP:
        if (last) begin
          nxt    = ST_IDLE;
          finish = 1'b1;
        end
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      st     <= nxt;
      scl_oe <= (nxt == ST_LOW) || (nxt == ST_SLOW);
      sda_oe <= (nxt == ST_START) || (nxt == ST_SLOW) || (nxt == ST_SHIGH);
      busy   <= (nxt != ST_IDLE);
      done   <= finish;
      if (accept)       fail <= 1'b0;
      else if (give_up) fail <= 1'b1;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  fail_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (done && pulse_cnt == CW'(MAX_PULSES)));

  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (st == ST_START || st == ST_STOP));

  // R2
  req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req) |=> (pulse_cnt >= $past(pulse_cnt)));
endmodule

// File: tb/tb_bus_recover.sv
module tb_bus_recover;
  localparam int HALF = 4;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic scl_oe, sda_oe, busy, done, fail;
  logic sda_line;

  int checks = 0;
  int fails  = 0;

  int release_at = 0;
  int rises_all  = 0;
  int pulses, starts, stops, hi_edges, low_cyc, done_cnt;
  logic scl_p = 1'b0, sda_p = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = (rises_all < release_at) ? 1'b0 : !sda_oe;

  bus_recover #(.HALF_CYCLES(HALF), .MAX_PULSES(MAXP), .SYNC_STAGES(2)) dut (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .sda_i  (sda_line),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .busy   (busy),
    .done   (done),
    .fail   (fail)
  );

  always @(negedge clk) begin
    if (scl_p && !scl_oe) begin
      rises_all = rises_all + 1;
      if (!sda_oe) pulses = pulses + 1;
    end
    if (!scl_oe && !scl_p && (sda_oe != sda_p)) begin
      hi_edges = hi_edges + 1;
      if (sda_oe) starts = starts + 1;
      else        stops  = stops + 1;
    end
    if (scl_oe) low_cyc = low_cyc + 1;
    if (done)   done_cnt = done_cnt + 1;
    scl_p = scl_oe;
    sda_p = sda_oe;
  end

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int k);
    int p_exp, ok_exp, waited;
    @(negedge clk);
    release_at = k;
    rises_all = 0; pulses = 0; starts = 0; stops = 0;
    hi_edges = 0; low_cyc = 0; done_cnt = 0;
    p_exp  = (k == 0) ? 1 : ((k <= MAXP) ? k : MAXP);
    ok_exp = (k <= MAXP) ? 1 : 0;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (9) @(negedge clk);
    req = 1'b1;                       // R2: ignored while busy
    @(negedge clk);
    req = 1'b0;
    waited = 0;
    while (done_cnt == 0 && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    chk(fail == !ok_exp, "R7 fail flag", fail, !ok_exp);
    repeat (30) @(negedge clk);
    chk(done_cnt == 1, "R8/R2 done pulses", done_cnt, 1);
    chk(pulses == p_exp, "R4/R5 pulse count", pulses, p_exp);
    chk(starts == ok_exp, "R6 start edges", starts, ok_exp);
    chk(stops == ok_exp, "R6 stop edges", stops, ok_exp);
    chk(hi_edges == 2 * ok_exp, "R9 sda edges with scl high", hi_edges, 2 * ok_exp);
    chk(low_cyc == HALF * (p_exp + ok_exp), "R3 scl low cycles", low_cyc, HALF * (p_exp + ok_exp));
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    chk(!busy, "R2 no second sequence", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_oe == 1'b0, "R1 scl_oe reset", scl_oe, 0);
    chk(sda_oe == 1'b0, "R1 sda_oe reset", sda_oe, 0);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    chk(fail == 1'b0, "R1 fail reset", fail, 0);
    for (int k = 0; k <= MAXP + 1; k++) run_case(k);
    run_case(MAXP + 1);
    run_case(3);                      // fail flag must clear on new request
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule